// File: doc/BRIEF.md
# Interrupt Acceptance Timing Sequencer

This block decides the moment at which a small 8-bit controller takes a pending hardware interrupt, and how many clocks the controller then spends on acceptance. Each request line sets a sticky pending flag. The flag then matures for a fixed priority-resolution interval. A matured, enabled request is taken only at an instruction-completion strobe. The strobe must come with acceptance globally allowed, and the completing instruction must not be one that defers interrupts.

When a request is taken, the sequencer clears that request's flag and picks an acceptance latency. The latency depends on the instruction-fetch mode bit, on the memory region that the stack pointer falls in, and on the number of external wait cycles. The sequencer counts this latency down and then raises a one-clock handler-start pulse together with the index of the request it took. It does not decode instructions, move macro-service data or fetch vectors. The surrounding pipeline supplies the boundary and deferral strobes.

Top module: `irq_accept_seq`

## Requirements
- R1: A one-clock high on `req_pulse[i]` sets pending flag i. The flag stays set until that request is accepted. A request disabled by `req_mask[i]=0` is never accepted, but its flag stays set, and the request is accepted at a later boundary once it is enabled again.
- R2: A flag set by the clock edge that samples the pulse needs 3 further clock edges of priority resolution. A boundary presented within those 3 clocks does not accept the request. A boundary presented on the clock after them does accept it.
- R3: Acceptance happens only in a cycle where `instr_done=1`, `irq_allow=1` and `instr_defer=0`. A boundary with `instr_defer=1` or `irq_allow=0` takes nothing, and the request waits for the next qualifying boundary.
- R4: Among matured, enabled requests, the highest 2-bit level wins; a larger value means higher priority. The level of request i is `req_prio[2*i+1:2*i]`. When levels tie, the lowest index wins.
- R5: Accepting a request clears only its own flag. The other pending requests are taken at later boundaries.
- R6: When `fetch_int=1`, the acceptance latency is 18 clocks for an internal-RAM stack, 24 for a peripheral-RAM stack and 24+3w for an external-memory stack, where w is `wait_cnt`.
- R7: When `fetch_int=0`, the latency is 24+3w for an internal-RAM stack, 30+3w for a peripheral-RAM stack and 30+6w for an external-memory stack.
- R8: `stack_addr` from 0xFE00 to 0xFEFF inclusive counts as internal RAM. Other addresses from 0xFD00 to 0xFDFF count as peripheral RAM. Every other address counts as external memory. The mode bit, the address and the wait count are sampled in the accepting cycle.
- R9: `handler_go` is high for exactly one clock, L clocks after the accepting clock edge, where L is the latency from R6 or R7. While it is high, `handler_idx` carries the index of the accepted request.
- R10: While a latency count runs, boundaries are ignored and new requests stay pending. They are evaluated at boundaries from the handler-start pulse onward.
- R11: After reset no flag is pending, `handler_go` is low and `handler_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pulse | input | 4 | Hardware request events, one bit per source |
| req_mask | input | 4 | Per-source enable, 1 = may be accepted |
| req_prio | input | 8 | Two-bit priority level per source |
| irq_allow | input | 1 | Global acceptance allowed |
| instr_done | input | 1 | Current instruction completes this cycle |
| instr_defer | input | 1 | Completing instruction defers interrupts |
| fetch_int | input | 1 | 1 = internal-ROM fetch timing |
| stack_addr | input | 16 | Stack pointer address |
| wait_cnt | input | 3 | External wait cycles w |
| handler_go | output | 1 | One-clock handler-start pulse |
| handler_idx | output | 2 | Index of the accepted request |

## Verification
The latency is measured from the accepting boundary to the pulse. This is done for all six fetch/stack pairings, with a nonzero wait count, so that any mix-up between the 3w and 6w terms or between the two fetch tables shows up. Stack addresses on each side of both region edges separate the inclusive internal-RAM range from its neighbours. One run holds the boundary strobe high from the request onward; it pins the resolution delay to exactly three clocks. Directed patterns then test the remaining rules: equal and unequal priority levels, a masked request, and deferring or disallowed boundaries. A request and boundaries arriving during a count show that ordering, gating and the busy-time hold are each enforced.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        REG_INT  = 2'd0,
        REG_PERI = 2'd1,
        REG_EXT  = 2'd2
    } stack_region_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } acc_state_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NUM_REQ  = 4,
    parameter int RES_CLKS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] set_i,
    input  logic [NUM_REQ-1:0] clr_i,
    output logic [NUM_REQ-1:0] flag_o,
    output logic [NUM_REQ-1:0] ready_o
);

    localparam int AGE_W = $clog2(RES_CLKS + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(RES_CLKS);

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        logic             flag_d, flag_q;
        logic [AGE_W-1:0] age_d, age_q;

        always_comb begin
            flag_d = flag_q;
            age_d  = age_q;
            if (clr_i[g]) begin
                flag_d = 1'b0;
            end
            if (set_i[g] && (!flag_q || clr_i[g])) begin
                flag_d = 1'b1;
                age_d  = '0;
            end else if (flag_q && (age_q != AGE_MAX)) begin
                age_d = age_q + AGE_W'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
                age_q  <= '0;
            end else begin
                flag_q <= flag_d;
                age_q  <= age_d;
            end
        end

        assign flag_o[g]  = flag_q;
        assign ready_o[g] = flag_q && (age_q == AGE_MAX);

        // R1: a pending flag is only dropped by acceptance
        p_flag_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[g] && !clr_i[g]) |=> flag_o[g]);

        // R2: maturity never appears on a flag that was not already set
        p_ready_after_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ready_o[g]) |-> $past(flag_o[g]));
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_REQ = 4,
    parameter int PRIO_W  = 2,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0]        cand_i,
    input  logic [NUM_REQ*PRIO_W-1:0] prio_i,
    output logic                      any_o,
    output logic [IDX_W-1:0]          idx_o,
    output logic [NUM_REQ-1:0]        win_o
);

    logic [PRIO_W-1:0] best_lvl;

    always_comb begin
        any_o    = 1'b0;
        idx_o    = '0;
        best_lvl = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (cand_i[i] && (!any_o || (prio_i[i*PRIO_W +: PRIO_W] > best_lvl))) begin
                any_o    = 1'b1;
                best_lvl = prio_i[i*PRIO_W +: PRIO_W];
                idx_o    = IDX_W'(i);
            end
        end
        win_o = any_o ? (NUM_REQ'(1) << idx_o) : '0;
    end

    // R4: at most one winner, and only among candidates
    always_comb begin
        a_single_win_r4: assert ($onehot0(win_o));
        a_win_is_cand_r4: assert ((win_o & ~cand_i) == '0);
    end

endmodule

// File: rtl/irq_stack_class.sv
module irq_stack_class
    import irq_seq_pkg::*;
#(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] IRAM_LO = 16'hFE00,
    parameter logic [ADDR_W-1:0] IRAM_HI = 16'hFEFF,
    parameter logic [ADDR_W-1:0] PERI_LO = 16'hFD00,
    parameter logic [ADDR_W-1:0] PERI_HI = 16'hFDFF
) (
    input  logic [ADDR_W-1:0] addr_i,
    output stack_region_e     region_o
);

    logic in_iram, in_peri;

    always_comb begin
        in_iram = (addr_i >= IRAM_LO) && (addr_i <= IRAM_HI);
        in_peri = (addr_i >= PERI_LO) && (addr_i <= PERI_HI);
        if (in_iram) begin
            region_o = REG_INT;
        end else if (in_peri) begin
            region_o = REG_PERI;
        end else begin
            region_o = REG_EXT;
        end
    end

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
    import irq_seq_pkg::*;
#(
    parameter int NUM_REQ  = 4,
    parameter int PRIO_W   = 2,
    parameter int ADDR_W   = 16,
    parameter int WAIT_W   = 3,
    parameter int RES_CLKS = 3,
    localparam int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_pulse,
    input  logic [NUM_REQ-1:0]        req_mask,
    input  logic [NUM_REQ*PRIO_W-1:0] req_prio,
    input  logic                      irq_allow,
    input  logic                      instr_done,
    input  logic                      instr_defer,
    input  logic                      fetch_int,
    input  logic [ADDR_W-1:0]         stack_addr,
    input  logic [WAIT_W-1:0]         wait_cnt,
    output logic                      handler_go,
    output logic [IDX_W-1:0]          handler_idx
);

    localparam int LAT_MAX = 30 + 6 * ((1 << WAIT_W) - 1);
    localparam int LAT_W   = $clog2(LAT_MAX + 1);

    typedef struct packed {
        acc_state_e       st;
        logic [LAT_W-1:0] cnt;
        logic             go;
        logic [IDX_W-1:0] idx;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [NUM_REQ-1:0] flags, ready, cand, win_vec, clr_vec;
    logic               any_cand, take;
    logic [IDX_W-1:0]   win_idx;
    stack_region_e      region;
    logic [LAT_W-1:0]   w_x3, lat;

    irq_flag_bank #(
        .NUM_REQ (NUM_REQ),
        .RES_CLKS(RES_CLKS)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_pulse),
        .clr_i  (clr_vec),
        .flag_o (flags),
        .ready_o(ready)
    );

    assign cand = ready & req_mask;

    irq_prio_pick #(
        .NUM_REQ(NUM_REQ),
        .PRIO_W (PRIO_W)
    ) u_pick (
        .cand_i(cand),
        .prio_i(req_prio),
        .any_o (any_cand),
        .idx_o (win_idx),
        .win_o (win_vec)
    );

    irq_stack_class #(
        .ADDR_W(ADDR_W)
    ) u_class (
        .addr_i  (stack_addr),
        .region_o(region)
    );

    // acceptance latency from fetch mode, stack region and wait count
    always_comb begin
        w_x3 = LAT_W'(wait_cnt) * LAT_W'(3);
        if (fetch_int) begin
            unique case (region)
                REG_INT:  lat = LAT_W'(18);
                REG_PERI: lat = LAT_W'(24);
                default:  lat = LAT_W'(24) + w_x3;
            endcase
        end else begin
            unique case (region)
                REG_INT:  lat = LAT_W'(24) + w_x3;
                REG_PERI: lat = LAT_W'(30) + w_x3;
                default:  lat = LAT_W'(30) + w_x3 + w_x3;
            endcase
        end
    end

    always_comb begin
        r_d     = r_q;
        r_d.go  = 1'b0;
        take    = (r_q.st == ST_IDLE) && instr_done && !instr_defer
                  && irq_allow && any_cand;
        clr_vec = take ? win_vec : '0;
        if (take) begin
            r_d.st  = ST_COUNT;
            r_d.cnt = lat - LAT_W'(1);
            r_d.idx = win_idx;
        end else if (r_q.st == ST_COUNT) begin
            if (r_q.cnt == '0) begin
                r_d.st = ST_IDLE;
                r_d.go = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt - LAT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, go: 1'b0, idx: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign handler_go  = r_q.go;
    assign handler_idx = r_q.idx;

    // R9: start pulse lasts a single clock
    p_go_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        handler_go |=> !handler_go);

    // R9: the latency counter steps down by one each clock
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_COUNT && r_q.cnt != '0) |=>
        (r_q.st == ST_COUNT && r_q.cnt == $past(r_q.cnt) - LAT_W'(1)));

    // R3: a count only starts after a qualifying boundary
    p_accept_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == ST_COUNT) |-> $past(instr_done && !instr_defer && irq_allow));

    // R10: no pending flag is consumed while counting
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_COUNT) |=> ((flags & $past(flags)) == $past(flags)));

    // R6: no latency below the shortest table entry
    p_lat_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == ST_COUNT) |-> (r_q.cnt >= LAT_W'(17)));

endmodule

// File: tb/irq_accept_seq_tb.sv
module irq_accept_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_pulse = '0;
    logic [3:0] req_mask = 4'hF;
    logic [7:0] req_prio = '0;
    logic       irq_allow = 1'b1;
    logic       instr_done = 1'b0;
    logic       instr_defer = 1'b0;
    logic       fetch_int = 1'b1;
    logic [15:0] stack_addr = 16'hFE80;
    logic [2:0] wait_cnt = '0;
    logic       handler_go;
    logic [1:0] handler_idx;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    irq_accept_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .req_mask(req_mask),
        .req_prio(req_prio), .irq_allow(irq_allow), .instr_done(instr_done),
        .instr_defer(instr_defer), .fetch_int(fetch_int), .stack_addr(stack_addr),
        .wait_cnt(wait_cnt), .handler_go(handler_go), .handler_idx(handler_idx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_lat(input bit fi, input logic [15:0] a, input int w);
        int reg_k;
        if (a >= 16'hFE00 && a <= 16'hFEFF) reg_k = 0;
        else if (a >= 16'hFD00 && a <= 16'hFDFF) reg_k = 1;
        else reg_k = 2;
        if (fi) return (reg_k == 0) ? 18 : (reg_k == 1) ? 24 : 24 + 3 * w;
        return (reg_k == 0) ? 24 + 3 * w : (reg_k == 1) ? 30 + 3 * w : 30 + 6 * w;
    endfunction

    task automatic pulse(input logic [3:0] v);
        req_pulse = v;
        @(negedge clk);
        req_pulse = '0;
        repeat (5) @(negedge clk);
    endtask

    // present one boundary and measure clocks from the accepting edge to the pulse
    task automatic measure(input int exp_l, input int exp_i, input string tag);
        int cyc = 0;
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            cyc++;
            if (handler_go) break;
        end
        check(cyc == exp_l, {tag, " latency"}, cyc, exp_l);
        check(handler_idx == exp_i, {tag, " index"}, handler_idx, exp_i);
        @(negedge clk);
        check(handler_go == 1'b0, {tag, " one-clock pulse"}, handler_go, 0);
    endtask

    task automatic expect_quiet(input int n, input string tag);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (handler_go) seen++;
        end
        check(seen == 0, tag, seen, 0);
    endtask

    task automatic t_reset();
        check(handler_go == 1'b0, "R11 go after reset", handler_go, 0);
        check(handler_idx == 2'd0, "R11 idx after reset", handler_idx, 0);
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        expect_quiet(25, "R11 no flag pending after reset");
    endtask

    task automatic t_resolve();
        int cyc = 0;
        req_pulse = 4'b0001;
        @(negedge clk);
        req_pulse = '0;
        instr_done = 1'b1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            cyc++;
            if (handler_go) break;
        end
        instr_done = 1'b0;
        // flag edge + 3 resolution clocks + accepting edge + 18
        check(cyc == 22, "R2 resolution delay with constant boundaries", cyc, 22);
        @(negedge clk);
    endtask

    task automatic t_defer();
        pulse(4'b0001);
        instr_done = 1'b1; instr_defer = 1'b1;
        @(negedge clk);
        instr_done = 1'b0; instr_defer = 1'b0;
        expect_quiet(25, "R3 deferring boundary takes nothing");
        irq_allow = 1'b0; instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0; irq_allow = 1'b1;
        expect_quiet(25, "R3 disallowed boundary takes nothing");
        measure(18, 0, "R3 next boundary");
    endtask

    task automatic t_priority();
        req_prio = {2'd3, 2'd3, 2'd1, 2'd0};   // req3=3 req2=3 req1=1 req0=0
        pulse(4'b1110);
        measure(18, 2, "R4 tie goes to lower index");
        measure(18, 3, "R5 remaining equal level");
        measure(18, 1, "R5 lowest level last");
        req_prio = {2'd0, 2'd0, 2'd2, 2'd1};
        pulse(4'b0011);
        measure(18, 1, "R4 higher level beats lower index");
        measure(18, 0, "R5 other request kept");
        req_prio = '0;
    endtask

    task automatic t_mask();
        req_prio = {2'd0, 2'd0, 2'd0, 2'd3};
        req_mask = 4'b1110;
        pulse(4'b0011);
        measure(18, 1, "R1 masked source skipped");
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        expect_quiet(25, "R1 masked source not taken");
        req_mask = 4'hF;
        measure(18, 0, "R1 masked flag still pending");
        req_prio = '0;
    endtask

    task automatic t_latency();
        logic [15:0] addrs [6] = '{16'hFE00, 16'hFEFF, 16'hFDFF, 16'hFD00, 16'hFF00, 16'hFCFF};
        for (int f = 0; f < 2; f++) begin
            for (int a = 0; a < 6; a++) begin
                fetch_int = f[0];
                stack_addr = addrs[a];
                wait_cnt = 3'd2 + 3'(a % 2) * 3'd5;
                pulse(4'b0100);
                measure(exp_lat(f[0], addrs[a], int'(wait_cnt)), 2,
                        f[0] ? "R6 R8 internal fetch" : "R7 R8 external fetch");
            end
        end
        fetch_int = 1'b1; stack_addr = 16'hFE80; wait_cnt = '0;
    endtask

    task automatic t_busy();
        int cyc = 0;
        pulse(4'b0001);
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        for (int k = 0; k < 100; k++) begin
            req_pulse  = (cyc == 2) ? 4'b0010 : 4'b0000;
            instr_done = (cyc >= 8 && cyc <= 12);
            @(negedge clk);
            cyc++;
            if (handler_go) break;
        end
        req_pulse = '0; instr_done = 1'b0;
        check(cyc == 18, "R10 count unaffected by boundaries", cyc, 18);
        check(handler_idx == 0, "R10 first request index", handler_idx, 0);
        expect_quiet(25, "R10 new request waits for a boundary");
        measure(18, 1, "R10 request taken after pulse");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_resolve();
        t_defer();
        t_priority();
        t_mask();
        t_latency();
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule